// File: doc/BRIEF.md
# Lockable Watchdog Timer with Prescaler

A 16-bit down-counting timer that either runs as a free periodic timer raising a sticky interrupt, or guards system software as a watchdog. It counts rising edges of a slow low-power clock, which is brought into the bus clock domain through a synchronizer and then divided by a selectable prescaler. Software reaches it through four word registers: a reload value, a read-only current count, a control word and a write-any clear register.

Once the watchdog mode bit is set, the reload and control registers freeze until the next power-on reset. On expiry the block reloads itself and raises either a one-cycle reset request or the interrupt. A warm reset clears only the interrupt and leaves counting and configuration untouched. Counting stops while a debug halt input is high. It can also stop during power-down when software asks for that.

Top module: `wdt_timer`

## Requirements
- R1: After rst_ni the reload register reads 0x0040, control reads 0, the count reads 0x0040, and irq_o and rst_req_o are low.
- R2: addr_i selects the reload register (0, read/write), the count (1, read-only; writes ignored), the control word (2) and the clear register (3, reads 0). Control fields are: bit 0 power-down stop, bit 1 expiry action, bits 3:2 divider, bit 5 watchdog mode and bit 7 run. Bits 4 and 6 read as 0.
- R3: Each rising edge of lp_clk_i yields one tick once synchronized. On every prescaled tick the count decrements, and a count of 0 reloads from the reload register instead. Counting is enabled when run or watchdog mode is set.
- R4: Divider field 0 gives /1, field 1 gives /16, and fields 2 and 3 give /256. A control or clear write restarts the prescaler.
- R5: An expiry in normal mode, or in watchdog mode with action bit 1 set, sets irq_o until it is cleared.
- R6: An expiry in watchdog mode with action bit 0 produces a single-cycle pulse on rst_req_o.
- R7: Any write to the clear register reloads the count from the reload register and clears irq_o.
- R8: While watchdog mode is set, writes to the reload and control registers are ignored until rst_ni.
- R9: warm_rst_i clears irq_o. Count, control, reload and lock are unaffected, and counting continues.
- R10: While dbg_halt_i is high, no tick changes the count.
- R11: With control bit 0 clear, counting continues while pwr_down_i is high. With it set, counting stops while pwr_down_i is high.
- R12: An accepted control write reloads the count from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| warm_rst_i | input | 1 | Synchronous non-power-on reset |
| lp_clk_i | input | 1 | Slow low-power clock, asynchronous |
| dbg_halt_i | input | 1 | Debug access, freezes counting |
| pwr_down_i | input | 1 | Power-down indication |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| irq_o | output | 1 | Sticky interrupt |
| rst_req_o | output | 1 | Single-cycle reset request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, two synchronizer stages, and dividers of 16 and 256. These dividers are small enough that a full /256 prescaled step takes a few thousand bus cycles, so every divider setting is exercised directly. A 16-bit count still lets small reload values drive repeated expiries, reloads from zero and reset pulses within a short run. The random phase keeps the divider at /1 or /16 and leaves watchdog mode off, so hundreds of mixed writes, halts and power-down changes can be compared against a reference model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ADDR_LOAD  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_CLEAR = 2'd3
  } wdt_addr_e;

  typedef struct packed {
    logic       run;
    logic       rsvd6;
    logic       wd_mode;
    logic       rsvd4;
    logic [1:0] div_sel;
    logic       irq_act;
    logic       pd_stop;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_clk_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lp_clk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_MID = 16,
  parameter int unsigned DIV_MAX = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       ptick_o
);
  localparam int unsigned PW = $clog2(DIV_MAX);

  logic [PW-1:0] cnt_q, lim;
  logic          step;

  always_comb begin
    unique case (sel_i)
      2'd0:    lim = '0;
      2'd1:    lim = PW'(DIV_MID - 1);
      default: lim = PW'(DIV_MAX - 1);
    endcase
  end

  assign step    = tick_i & en_i;
  assign ptick_o = step & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step)      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned W      = 16,
  parameter logic [W-1:0] LD_RST = 16'h0040
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         ptick_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  // bus reload wins over a coincident tick
  assign expire_o = ptick_i & ~load_i & (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= LD_RST;
    else if (load_i)  cnt_q <= ld_val_i;
    else if (ptick_i) cnt_q <= (cnt_q == '0) ? ld_val_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_MID     = 16,
  parameter int unsigned DIV_MAX     = 256,
  parameter logic [CNT_W-1:0] LD_RST = 16'h0040
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             lp_clk_i,
  input  logic             dbg_halt_i,
  input  logic             pwr_down_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  import wdt_pkg::*;

  wdt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] ld_q, cnt_q;
  logic             irq_q, rst_req_q;
  logic             locked, wr_load, wr_ctrl, wr_clear, reload;
  logic             count_en, tick, ptick, expire, to_reset;

  assign locked   = ctrl_q.wd_mode;
  assign wr_load  = wr_i && (addr_i == ADDR_LOAD) && !locked;
  assign wr_ctrl  = wr_i && (addr_i == ADDR_CTRL) && !locked;
  assign wr_clear = wr_i && (addr_i == ADDR_CLEAR);
  assign reload   = wr_ctrl | wr_clear;
  assign count_en = (ctrl_q.run | ctrl_q.wd_mode) & ~dbg_halt_i
                  & ~(ctrl_q.pd_stop & pwr_down_i);
  assign to_reset = ctrl_q.wd_mode & ~ctrl_q.irq_act;

  wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .lp_clk_i(lp_clk_i), .tick_o(tick)
  );

  wdt_prescaler #(.DIV_MID(DIV_MID), .DIV_MAX(DIV_MAX)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(reload), .tick_i(tick),
    .en_i(count_en), .sel_i(ctrl_q.div_sel), .ptick_o(ptick)
  );

  wdt_counter #(.W(CNT_W), .LD_RST(LD_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(reload), .ptick_i(ptick),
    .ld_val_i(ld_q), .cnt_o(cnt_q), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q      <= LD_RST;
      ctrl_q    <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_load) ld_q <= wdata_i;
      if (wr_ctrl) begin
        ctrl_q       <= wdt_ctrl_t'(wdata_i[7:0]);
        ctrl_q.rsvd6 <= 1'b0;
        ctrl_q.rsvd4 <= 1'b0;
      end
      if (wr_clear || warm_rst_i)   irq_q <= 1'b0;
      else if (expire && !to_reset) irq_q <= 1'b1;
      rst_req_q <= expire & to_reset;
    end
  end

  always_comb begin
    unique case (wdt_addr_e'(addr_i))
      ADDR_LOAD:  rdata_o = ld_q;
      ADDR_COUNT: rdata_o = cnt_q;
      ADDR_CTRL:  rdata_o = CNT_W'(ctrl_q);
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [1:0]         addr_i,
  input logic               dbg_halt_i,
  input logic               irq_o,
  input logic               rst_req_o,
  input wdt_pkg::wdt_ctrl_t ctrl_q,
  input logic [W-1:0]       ld_q,
  input logic [W-1:0]       cnt_q
);
  logic reload_cond;
  assign reload_cond = wr_i && (addr_i == 2'd3 || (addr_i == 2'd2 && !ctrl_q.wd_mode));

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.wd_mode |=> $stable(ctrl_q) && $stable(ld_q)); // R8
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_RST_ONLY_WD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ctrl_q.wd_mode && !ctrl_q.irq_act); // R6
  AST_CLR_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3) |=> cnt_q == $past(ld_q) && !irq_o); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_halt_i && !reload_cond) |=> $stable(cnt_q)); // R10
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_cond |=> cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - W'(1)
                     || ($past(cnt_q) == '0 && cnt_q == $past(ld_q))); // R3
endmodule

bind wdt_timer wdt_timer_chk #(.W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .dbg_halt_i(dbg_halt_i), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .ctrl_q(ctrl_q), .ld_q(ld_q), .cnt_q(cnt_q)
);

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, warm_rst_i = 1'b0, lp_clk_i = 1'b0;
  logic        dbg_halt_i = 1'b0, pwr_down_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0, failures = 0, cycles = 0, pulses = 0, high_cycles = 0;
  logic [15:0] m_ld, m_cnt;
  logic [7:0]  m_ctrl;
  int          m_pre, m_pulses;
  logic        m_irq, prev_rst;

  always #4 clk = ~clk;

  wdt_timer u_wdt_timer (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i), .lp_clk_i(lp_clk_i),
    .dbg_halt_i(dbg_halt_i), .pwr_down_i(pwr_down_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prev_rst <= rst_req_o;
    if (rst_req_o) high_cycles <= high_cycles + 1;
    if (rst_req_o && !prev_rst) pulses <= pulses + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 1 : (sel == 2'd1) ? 16 : 256;
  endfunction

  task automatic model_reset();
    m_ld = 16'h0040; m_cnt = 16'h0040; m_ctrl = 8'h00; m_pre = 0; m_irq = 1'b0;
  endtask

  task automatic por();
    @(negedge clk); rst_ni = 1'b0; lp_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; model_reset();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
    case (a)
      2'd0: if (!m_ctrl[5]) m_ld = d;
      2'd2: if (!m_ctrl[5]) begin m_ctrl = d[7:0] & 8'hAF; m_cnt = m_ld; m_pre = 0; end
      2'd3: begin m_cnt = m_ld; m_pre = 0; m_irq = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic slow_edge();
    bit en;
    @(negedge clk); lp_clk_i = 1'b1;
    repeat (8) @(negedge clk); lp_clk_i = 1'b0;
    repeat (8) @(negedge clk);
    en = (m_ctrl[7] | m_ctrl[5]) & !dbg_halt_i & !(m_ctrl[0] & pwr_down_i);
    if (en) begin
      m_pre++;
      if (m_pre >= div_of(m_ctrl[3:2])) begin
        m_pre = 0;
        if (m_cnt == 0) begin
          m_cnt = m_ld;
          if (m_ctrl[5] && !m_ctrl[1]) m_pulses++; else m_irq = 1'b1;
        end else m_cnt = m_cnt - 1'b1;
      end
    end
  endtask

  task automatic cmp(input string req);
    logic [15:0] d;
    rd(2'd1, d);
    check(req, d, m_cnt);
    check(req, irq_o, m_irq);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int p0;
    void'($urandom(32'd20240611));
    m_pulses = 0; prev_rst = 1'b0;
    por();
    // R1 reset state
    rd(2'd0, d); check("R1 load", d, 16'h0040);
    rd(2'd2, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 count", d, 16'h0040);
    check("R1 irq", irq_o, 0); check("R1 rst", rst_req_o, 0);
    // R2 count read-only, clear reads zero, reserved bits
    wr(2'd1, 16'h1234); cmp("R2 count ro");
    rd(2'd3, d); check("R2 clear reads 0", d, 0);
    wr(2'd2, 16'h0050); rd(2'd2, d); check("R2 reserved", d, 16'h0000);
    // R3/R5 normal mode /1
    wr(2'd0, 16'd3); wr(2'd2, 16'h0080); cmp("R12 ctrl reload");
    for (int i = 0; i < 5; i++) begin slow_edge(); cmp("R3 count"); end
    check("R5 irq set", irq_o, 1);
    slow_edge(); cmp("R5 irq sticky");
    wr(2'd3, 16'h00); cmp("R7 clear");
    // R4 /16 and /256
    wr(2'd2, 16'h0084);
    for (int i = 0; i < 33; i++) slow_edge();
    cmp("R4 div16");
    wr(2'd2, 16'h0088);
    for (int i = 0; i < 257; i++) slow_edge();
    cmp("R4 div256");
    // R10 debug halt
    wr(2'd2, 16'h0080); dbg_halt_i = 1'b1;
    for (int i = 0; i < 3; i++) slow_edge();
    cmp("R10 halt"); dbg_halt_i = 1'b0;
    slow_edge(); cmp("R10 resume");
    // R11 power-down both settings
    pwr_down_i = 1'b1; slow_edge(); slow_edge(); cmp("R11 default runs");
    wr(2'd2, 16'h0081); slow_edge(); slow_edge(); cmp("R11 pd stop");
    pwr_down_i = 1'b0; slow_edge(); cmp("R11 pd resume");
    // R9 warm reset
    wr(2'd0, 16'd1); wr(2'd3, 0); slow_edge(); slow_edge(); check("R9 pre irq", irq_o, 1);
    @(negedge clk); warm_rst_i = 1'b1; @(negedge clk); warm_rst_i = 1'b0; m_irq = 1'b0;
    cmp("R9 warm"); rd(2'd2, d); check("R9 ctrl kept", d, 16'h0081);
    slow_edge(); cmp("R9 continues");
    // random phase, watchdog mode excluded
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 8)
        0: wr(2'd0, 16'($urandom % 12));
        1: wr(2'd2, 16'($urandom & 32'h0087));
        2: wr(2'd3, 16'($urandom));
        3: begin @(negedge clk); dbg_halt_i = 1'($urandom); end
        4: begin @(negedge clk); pwr_down_i = 1'($urandom); end
        default: slow_edge();
      endcase
      cmp("R3 random");
    end
    dbg_halt_i = 1'b0; pwr_down_i = 1'b0;
    // R6/R8 watchdog with reset action
    wr(2'd0, 16'd2); wr(2'd2, 16'h0020);
    p0 = pulses; m_pulses = 0;
    for (int i = 0; i < 6; i++) slow_edge();
    cmp("R6 wd count");
    check("R6 pulses", pulses - p0, m_pulses);
    check("R6 width", high_cycles, pulses);
    check("R6 irq stays low", irq_o, 0);
    wr(2'd0, 16'd9); wr(2'd2, 16'h0080);
    rd(2'd0, d); check("R8 load locked", d, 2);
    rd(2'd2, d); check("R8 ctrl locked", d, 16'h0020);
    slow_edge(); wr(2'd3, 0); cmp("R7 wd restart");
    @(negedge clk); warm_rst_i = 1'b1; @(negedge clk); warm_rst_i = 1'b0;
    slow_edge(); cmp("R9 wd survives");
    // R8 unlock by power-on reset, R5 watchdog interrupt action
    por(); rd(2'd2, d); check("R8 unlocked", d, 0);
    wr(2'd0, 16'd1); wr(2'd2, 16'h0022); p0 = pulses;
    slow_edge(); slow_edge(); cmp("R5 wd irq");
    check("R5 no pulse", pulses - p0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule